// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block sits behind a two-wire serial slave inside a small non-volatile memory. The slave front end tells it when a word address has been received, when each data byte has arrived, when a STOP ends the transfer and when a repeated START cuts it short. The block gathers up to one page of bytes (eight by default) in a local buffer. It keeps a mask of the slots that were actually loaded. The array itself is left alone until the transfer ends.

On an accepted STOP with at least one byte loaded and write protection low, the block starts one self-timed write cycle. Its length is a fixed number of system clocks that stands for the programming time. During the first page-sized stretch of that cycle it steps through the slots in ascending order and drives the array write port for each loaded slot. For the whole cycle it raises a busy flag and ignores every command from the front end. The shared address counter stays visible on an output so that later current-address reads start in the right place.

Top module: `pgwr_engine`

## Requirements
- R1: After reset `busy_o` and `arr_we_o` are low and `ptr_o` is zero.
- R2: Each accepted data byte is stored in the slot given by the low three bits of `ptr_o`. Those three bits then advance by one and wrap from 7 to 0, and the upper address bits stay unchanged.
- R3: When more than eight bytes arrive before STOP, a later byte replaces the earlier byte in the same slot. The commit writes each slot at most once, with its newest byte.
- R4: Nothing is written to the array before STOP. The first write happens in the cycle after the STOP is accepted. The slots are visited in ascending order 0 to 7, one per clock, and only loaded slots are written, each at address {upper bits of `ptr_o`, slot number}.
- R5: A commit holds `busy_o` high for exactly WR_CYCLES consecutive clocks, starting in the cycle after the STOP.
- R6: While `busy_o` is high, address loads, data bytes, START and STOP are all ignored. `ptr_o` stays constant and no byte enters the buffer.
- R7: If `wp_i` is high when STOP is accepted, nothing is written and `busy_o` stays low. The buffer is emptied.
- R8: A START accepted before STOP empties the buffer. No write follows, and `busy_o` stays low.
- R9: A STOP with no byte loaded leaves `busy_o` low and writes nothing.
- R10: After a commit `ptr_o` equals the address of the last received byte plus one, wrapped within its page.
- R11: An address load sets `ptr_o` to the loaded value and empties the buffer. When several commands arrive in one cycle, START wins over STOP, STOP over address load, and address load over a data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_addr_i | input | 1 | Word address received, load the counter |
| load_val_i | input | ADDR_W | Word address value |
| byte_vld_i | input | 1 | Data byte received strobe |
| byte_val_i | input | DATA_W | Data byte value |
| stop_i | input | 1 | STOP seen on the bus |
| start_i | input | 1 | START seen before STOP (abort) |
| wp_i | input | 1 | Write protect, blocks commit when high |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Internal write cycle in progress |
| ptr_o | output | ADDR_W | Current address counter value |

## Verification
The engine is tested with a single byte, then with a run that starts mid-page and crosses the page end. Those two show the in-page wrap and the ascending slot order of the commit. A ten-byte run tells overwritten slots apart from untouched ones. Protected, aborted, empty and reloaded transfers each must end with no array write. Commands given during a busy cycle are followed by a bare STOP, which shows whether any stray byte slipped into the buffer.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/pgwr_addr_ctr.sv
// Word address counter: loads a full address, advances only inside the page.
module pgwr_addr_ctr #(
    parameter int ADDR_W = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] ptr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load_i) begin
            ctr_d.ptr = load_val_i;
        end else if (step_i) begin
            ctr_d.ptr[SLOT_W-1:0] = ctr_q.ptr[SLOT_W-1:0] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign ptr_o = ctr_q.ptr;
endmodule

// File: rtl/pgwr_slot_store.sv
// Page buffer: one data register and one loaded flag per slot.
module pgwr_slot_store #(
    parameter int PAGE_BYTES = 8,
    parameter int DATA_W     = 8,
    parameter int SLOT_W     = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [SLOT_W-1:0]     wr_slot_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic                  clr_i,
    input  logic [SLOT_W-1:0]     rd_slot_i,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic [PAGE_BYTES-1:0] mask_o
);
    logic [DATA_W-1:0] data_arr [PAGE_BYTES];

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        typedef struct packed {
            logic              vld;
            logic [DATA_W-1:0] data;
        } slot_t;

        slot_t slot_d, slot_q;
        logic  hit;

        assign hit = wr_i && (wr_slot_i == SLOT_W'(s));

        always_comb begin
            slot_d = slot_q;
            if (clr_i) begin
                slot_d.vld = 1'b0;
            end else if (hit) begin
                slot_d.vld  = 1'b1;
                slot_d.data = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign data_arr[s] = slot_q.data;
        assign mask_o[s]   = slot_q.vld;
    end

    assign rd_data_o = data_arr[rd_slot_i];
endmodule

// File: rtl/pgwr_commit_seq.sv
// Self-timed write cycle: scans slots during the first PAGE_BYTES clocks,
// then waits out the rest of WR_CYCLES.
module pgwr_commit_seq
    import pgwr_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int WR_CYCLES  = 64,
    parameter int SLOT_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    output logic              busy_o,
    output logic              win_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WR_CYCLES - 1);
    localparam logic [CNT_W-1:0] SCAN_LEN  = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_w;

    assign last_w = (seq_q.st == SEQ_RUN) && (seq_q.cnt == LAST_CNT);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (go_i) begin
                    seq_d.st  = SEQ_RUN;
                    seq_d.cnt = '0;
                end
            end
            SEQ_RUN: begin
                if (last_w) begin
                    seq_d.st  = SEQ_IDLE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = (seq_q.st == SEQ_RUN);
    assign win_o  = busy_o && (seq_q.cnt < SCAN_LEN);
    assign slot_o = seq_q.cnt[SLOT_W-1:0];
    assign done_o = last_w;
endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int WR_CYCLES  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_val_i,
    input  logic              stop_i,
    input  logic              start_i,
    input  logic              wp_i,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_wdata_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);

    logic                  accept_w;
    logic                  cmd_abort_w, cmd_stop_w, cmd_load_w, cmd_byte_w;
    logic                  go_w, clr_w, done_w, win_w;
    logic [SLOT_W-1:0]     scan_slot_w;
    logic [DATA_W-1:0]     rd_data_w;
    logic [PAGE_BYTES-1:0] mask_w;

    // Command decode with fixed priority, all gated off while busy.
    assign accept_w    = !busy_o;
    assign cmd_abort_w = accept_w && start_i;
    assign cmd_stop_w  = accept_w && !start_i && stop_i;
    assign cmd_load_w  = accept_w && !start_i && !stop_i && load_addr_i;
    assign cmd_byte_w  = accept_w && !start_i && !stop_i && !load_addr_i && byte_vld_i;

    assign go_w  = cmd_stop_w && (|mask_w) && !wp_i;
    assign clr_w = cmd_abort_w || cmd_load_w || (cmd_stop_w && !go_w) || done_w;

    pgwr_addr_ctr #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W)
    ) ctr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cmd_load_w),
        .load_val_i (load_val_i),
        .step_i     (cmd_byte_w),
        .ptr_o      (ptr_o)
    );

    pgwr_slot_store #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W),
        .SLOT_W     (SLOT_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (cmd_byte_w),
        .wr_slot_i (ptr_o[SLOT_W-1:0]),
        .wr_data_i (byte_val_i),
        .clr_i     (clr_w),
        .rd_slot_i (scan_slot_w),
        .rd_data_o (rd_data_w),
        .mask_o    (mask_w)
    );

    pgwr_commit_seq #(
        .PAGE_BYTES (PAGE_BYTES),
        .WR_CYCLES  (WR_CYCLES),
        .SLOT_W     (SLOT_W)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go_w),
        .busy_o (busy_o),
        .win_o  (win_w),
        .slot_o (scan_slot_w),
        .done_o (done_w)
    );

    assign arr_we_o    = win_w && mask_w[scan_slot_w];
    assign arr_addr_o  = {ptr_o[ADDR_W-1:SLOT_W], scan_slot_w};
    assign arr_wdata_o = rd_data_w;
endmodule

// File: rtl/pgwr_engine_chk.sv
module pgwr_engine_chk #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int WR_CYCLES  = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  load_addr_i,
    input logic                  byte_vld_i,
    input logic                  stop_i,
    input logic                  start_i,
    input logic                  wp_i,
    input logic                  arr_we_o,
    input logic [ADDR_W-1:0]     arr_addr_o,
    input logic                  busy_o,
    input logic [ADDR_W-1:0]     ptr_o,
    input logic [PAGE_BYTES-1:0] mask_w
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);

    int unsigned run_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= 0;
        end else if (busy_o) begin
            run_len_q <= run_len_q + 1;
        end else begin
            run_len_q <= 0;
        end
    end

    a_r1_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o);

    a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !busy_o && !start_i && !stop_i && !load_addr_i) |=>
        ((ptr_o[SLOT_W-1:0] == SLOT_W'($past(ptr_o[SLOT_W-1:0]) + 1'b1)) &&
         (ptr_o[ADDR_W-1:SLOT_W] == $past(ptr_o[ADDR_W-1:SLOT_W]))));

    a_r4_write_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> (arr_addr_o[ADDR_W-1:SLOT_W] == ptr_o[ADDR_W-1:SLOT_W]));

    a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len_q == WR_CYCLES));

    a_r6_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ptr_o));

    a_r7_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && wp_i && !busy_o && !start_i) |=> !busy_o);

    a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> !busy_o);

    a_r9_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && !start_i && (mask_w == '0)) |=> !busy_o);
endmodule

bind pgwr_engine pgwr_engine_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_addr_i (load_addr_i),
    .byte_vld_i  (byte_vld_i),
    .stop_i      (stop_i),
    .start_i     (start_i),
    .wp_i        (wp_i),
    .arr_we_o    (arr_we_o),
    .arr_addr_o  (arr_addr_o),
    .busy_o      (busy_o),
    .ptr_o       (ptr_o),
    .mask_w      (mask_w)
);

// File: tb/pgwr_engine_tb.sv
`timescale 1ns/1ps
module pgwr_engine_tb_top;
    localparam int TB_WR = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_addr_i = 1'b0;
    logic [7:0] load_val_i = '0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_val_i = '0;
    logic       stop_i = 1'b0;
    logic       start_i = 1'b0;
    logic       wp_i = 1'b0;
    logic       arr_we_o;
    logic [7:0] arr_addr_o;
    logic [7:0] arr_wdata_o;
    logic       busy_o;
    logic [7:0] ptr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int       wr_n = 0;
    int       busy_seen = 0;
    logic [7:0] wr_addr [32];
    logic [7:0] wr_data [32];

    always #4 clk = ~clk;

    pgwr_engine #(
        .ADDR_W(8), .DATA_W(8), .PAGE_BYTES(8), .WR_CYCLES(TB_WR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .load_addr_i(load_addr_i), .load_val_i(load_val_i),
        .byte_vld_i(byte_vld_i), .byte_val_i(byte_val_i),
        .stop_i(stop_i), .start_i(start_i), .wp_i(wp_i),
        .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_wdata_o(arr_wdata_o),
        .busy_o(busy_o), .ptr_o(ptr_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o) busy_seen++;
            if (arr_we_o && wr_n < 32) begin
                wr_addr[wr_n] = arr_addr_o;
                wr_data[wr_n] = arr_wdata_o;
                wr_n++;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        wr_n = 0;
        busy_seen = 0;
    endtask

    task automatic do_load(input logic [7:0] a);
        @(negedge clk); load_addr_i = 1'b1; load_val_i = a;
        @(negedge clk); load_addr_i = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        @(negedge clk); byte_vld_i = 1'b1; byte_val_i = d;
        @(negedge clk); byte_vld_i = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy", int'(busy_o), 0);
        check("R1 we", int'(arr_we_o), 0);
        check("R1 ptr", int'(ptr_o), 0);
    endtask

    task automatic t_single();
        clear_log();
        do_load(8'h35);
        do_byte(8'hA1);
        check("R2 ptr step", int'(ptr_o), 8'h36);
        repeat (3) @(negedge clk);
        check("R4 no early write", wr_n, 0);
        do_stop();
        check("R4 write next cycle", int'(arr_we_o), 0);
        wait_idle();
        check("R4 write count", wr_n, 1);
        check("R4 addr", int'(wr_addr[0]), 8'h35);
        check("R4 data", int'(wr_data[0]), 8'hA1);
        check("R5 busy cycles", busy_seen, TB_WR);
        check("R10 ptr after commit", int'(ptr_o), 8'h36);
    endtask

    task automatic t_wrap();
        clear_log();
        do_load(8'h46);
        do_byte(8'h11);
        do_byte(8'h22);
        do_byte(8'h33);
        check("R2 wrap ptr", int'(ptr_o), 8'h41);
        do_stop();
        wait_idle();
        check("R4 wrap count", wr_n, 3);
        check("R4 order 0 addr", int'(wr_addr[0]), 8'h40);
        check("R4 order 0 data", int'(wr_data[0]), 8'h33);
        check("R4 order 1 addr", int'(wr_addr[1]), 8'h46);
        check("R4 order 2 addr", int'(wr_addr[2]), 8'h47);
        check("R10 wrap ptr", int'(ptr_o), 8'h41);
    endtask

    task automatic t_overflow();
        clear_log();
        do_load(8'h80);
        for (int i = 0; i < 10; i++) do_byte(8'hD0 + 8'(i));
        do_stop();
        wait_idle();
        check("R3 one write per slot", wr_n, 8);
        check("R3 slot0 newest", int'(wr_data[0]), 8'hD8);
        check("R3 slot1 newest", int'(wr_data[1]), 8'hD9);
        check("R3 slot2 kept", int'(wr_data[2]), 8'hD2);
        check("R3 slot7 addr", int'(wr_addr[7]), 8'h87);
        check("R10 overflow ptr", int'(ptr_o), 8'h82);
    endtask

    task automatic t_protect();
        clear_log();
        do_load(8'h10);
        do_byte(8'h5A);
        wp_i = 1'b1;
        do_stop();
        repeat (3) @(negedge clk);
        wp_i = 1'b0;
        check("R7 no busy", busy_seen, 0);
        check("R7 no write", wr_n, 0);
        do_stop();
        repeat (3) @(negedge clk);
        check("R7 buffer emptied", busy_seen, 0);
    endtask

    task automatic t_abort();
        clear_log();
        do_load(8'h20);
        do_byte(8'h01);
        do_byte(8'h02);
        do_start();
        do_stop();
        repeat (3) @(negedge clk);
        check("R8 no busy", busy_seen, 0);
        check("R8 no write", wr_n, 0);
        // same-cycle START and STOP: START wins
        do_load(8'h70);
        do_byte(8'h03);
        @(negedge clk); start_i = 1'b1; stop_i = 1'b1;
        @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 start beats stop", busy_seen, 0);
    endtask

    task automatic t_empty();
        clear_log();
        do_load(8'h30);
        do_stop();
        repeat (3) @(negedge clk);
        check("R9 empty stop busy", busy_seen, 0);
        check("R9 empty stop write", wr_n, 0);
    endtask

    task automatic t_busy_ignore();
        clear_log();
        do_load(8'h50);
        do_byte(8'h11);
        do_stop();
        do_load(8'h00);
        do_byte(8'h99);
        do_start();
        do_stop();
        check("R6 ptr frozen", int'(ptr_o), 8'h51);
        wait_idle();
        check("R6 single write", wr_n, 1);
        check("R6 data intact", int'(wr_data[0]), 8'h11);
        clear_log();
        do_stop();
        repeat (3) @(negedge clk);
        check("R6 no stray byte", busy_seen, 0);
    endtask

    task automatic t_reload();
        clear_log();
        do_load(8'h60);
        do_byte(8'h01);
        do_load(8'h68);
        check("R11 load sets ptr", int'(ptr_o), 8'h68);
        do_byte(8'h02);
        do_stop();
        wait_idle();
        check("R11 reload count", wr_n, 1);
        check("R11 reload addr", int'(wr_addr[0]), 8'h68);
        check("R11 reload data", int'(wr_data[0]), 8'h02);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_single();
        t_wrap();
        t_overflow();
        t_protect();
        t_abort();
        t_empty();
        t_busy_ignore();
        t_reload();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule